// File: doc/BRIEF.md
# Bus receiver failsafe and standby controller

This block is the digital control core of a half-duplex differential line transceiver. Two comparator results arrive already digitised: one says the line difference is above the positive threshold, the other says it is below the negative threshold. After synchronising them, the block keeps the receiver data bit. When the line sits between the thresholds for too long, a fault timer forces that bit high. This stops a floating, shorted or idle line from being read as data.

The block also decodes the driver-enable, data and receiver-enable pins. From them it produces the driver output levels and their enable, the receiver output enable and a low-power standby flag. An open (unconnected) pin is marked by a per-pin flag and takes a fixed default. In standby the failsafe logic freezes. Waking from standby restarts the logic from a clean state.

The receive path is a four-state machine with these states:
- `ST_TRACK`: the last sample was valid. Reset and wake both enter this state.
- `ST_BAND`: the line is between the thresholds and the timer is counting.
- `ST_FAILSAFE`: the timer has expired.
- `ST_STANDBY`: frozen.

The transitions are:
- From any active state, a high or low sample goes to `ST_TRACK`.
- From `ST_TRACK`, an in-band sample goes to `ST_BAND`.
- `ST_BAND` goes to `ST_FAILSAFE` on its `FS_CYCLES`-th consecutive in-band sample.
- `ST_FAILSAFE` stays there while in-band samples continue.
- Any active state goes to `ST_STANDBY` when standby is decoded.
- `ST_STANDBY` goes to `ST_TRACK` when standby is released.

Top module: `bus_rx_guard`

## Requirements
- R1: When the synchronised sample has only the above-threshold flag set, `rx_data` becomes 1 and `fault` becomes 0. Both are visible three rising edges after the flag changes.
- R2: When the synchronised sample has only the below-threshold flag set, `rx_data` becomes 0 and `fault` becomes 0, with the same three-edge latency.
- R3: While samples are in-band (neither flag set), `rx_data` holds its last valid value and `fault` stays 0 for the first `FS_CYCLES`-1 in-band samples.
- R4: On the `FS_CYCLES`-th consecutive in-band sample, `rx_data` is forced to 1 and `fault` rises. Both stay that way while the line stays in-band. `fault` high always implies `rx_data` high.
- R5: A valid sample clears `fault` and restarts the timer. A new in-band run then needs the full `FS_CYCLES` samples before `fault` rises again.
- R6: A sample with both flags set counts as in-band.
- R7: `rx_oe` is the inverse of the effective receiver-enable, and it responds to that pin with no clock edge.
- R8: `drv_oe` equals the effective driver-enable. `drv_a` equals the effective data bit and `drv_b` is its complement. All of these respond with no clock edge.
- R9: An open driver-enable acts as 0, an open data pin acts as 1, and an open receiver-enable acts as 0.
- R10: `standby` is 1 exactly when the effective driver-enable is 0 and the effective receiver-enable is 1. While in standby, `rx_data`, `fault` and the timer do not change, whatever the line does.
- R11: On the first edge after standby is released, `rx_data` becomes 1 and `fault` becomes 0, and the timer is cleared.
- R12: During and right after reset, `rx_data` is 1 and `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| above_i | input | 1 | Comparator flag: difference above positive threshold |
| below_i | input | 1 | Comparator flag: difference below negative threshold |
| de_pin | input | 1 | Driver-enable pin level |
| de_open | input | 1 | Driver-enable pin unconnected |
| d_pin | input | 1 | Transmit data pin level |
| d_open | input | 1 | Transmit data pin unconnected |
| re_pin | input | 1 | Receiver-enable pin level (high disables the output) |
| re_open | input | 1 | Receiver-enable pin unconnected |
| rx_data | output | 1 | Receiver data bit |
| rx_oe | output | 1 | Receiver output enable (0 means high impedance) |
| drv_a | output | 1 | Driver non-inverting line level |
| drv_b | output | 1 | Driver inverting line level |
| drv_oe | output | 1 | Driver line enable (0 means both lines high impedance) |
| standby | output | 1 | Low-power standby is active |
| fault | output | 1 | Failsafe condition holds |

## Verification
The receive results `rx_data` and `fault` are due three rising edges after a comparator flag changes: two edges in the synchroniser and one in the state register. A standby release takes effect on the first edge after the pin change. The pin decode outputs are combinational, so they are due before the next edge. Every stimulus task records its expected values in a scoreboard queue, tagged with the exact cycle in which each is due. Inputs change on the falling edge and the monitor samples one nanosecond after each rising edge, comparing only the items due in that cycle. The failsafe boundary is checked on both sides: one cycle before the expiry sample and on the expiry sample itself.

// File: rtl/bus_rx_guard_pkg.sv
package bus_rx_guard_pkg;

    // Classified line level after synchronisation
    typedef enum logic [1:0] {
        LVL_BAND = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } bus_lvl_e;

    // Receive-path states
    typedef enum logic [1:0] {
        ST_TRACK    = 2'd0,
        ST_BAND     = 2'd1,
        ST_FAILSAFE = 2'd2,
        ST_STANDBY  = 2'd3
    } rx_state_e;

    // Pin vector indices
    localparam int PIN_DE = 0;
    localparam int PIN_D  = 1;
    localparam int PIN_RE = 2;
    localparam int NUM_PINS = 3;

    // Value an unconnected pin settles to, indexed as above
    localparam logic [NUM_PINS-1:0] PIN_OPEN_LEVEL = 3'b010;

    // Contradictory flags (both set) are treated as in-band
    function automatic bus_lvl_e classify(input logic above, input logic below);
        bus_lvl_e lvl;
        unique case ({above, below})
            2'b10:   lvl = LVL_HIGH;
            2'b01:   lvl = LVL_LOW;
            default: lvl = LVL_BAND;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pin_decoder.sv
module pin_decoder
    import bus_rx_guard_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] open_i,
    output logic                drv_oe_o,
    output logic                drv_a_o,
    output logic                drv_b_o,
    output logic                rx_oe_o,
    output logic                standby_o
);

    logic [NUM_PINS-1:0] eff;

    genvar p;
    generate
        for (p = 0; p < NUM_PINS; p++) begin : g_pin
            assign eff[p] = open_i[p] ? PIN_OPEN_LEVEL[p] : pin_i[p];
        end
    endgenerate

    always_comb begin
        drv_oe_o  = eff[PIN_DE];
        drv_a_o   = eff[PIN_D];
        drv_b_o   = ~eff[PIN_D];
        rx_oe_o   = ~eff[PIN_RE];
        standby_o = ~eff[PIN_DE] & eff[PIN_RE];
    end

    // R10
    standby_outputs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_o |-> (!drv_oe_o && !rx_oe_o));

endmodule

// File: rtl/rx_failsafe_fsm.sv
module rx_failsafe_fsm
    import bus_rx_guard_pkg::*;
#(
    parameter int FS_CYCLES = 62500
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  bus_lvl_e lvl_i,
    input  logic     sleep_i,
    output logic     rx_o,
    output logic     fault_o
);

    localparam int CNT_W = $clog2(FS_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FS_CYCLES - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rx_q, rx_d;

    // Next-state and data logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rx_d    = rx_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (!sleep_i) begin
                    state_d = ST_TRACK;
                    cnt_d   = '0;
                    rx_d    = 1'b1;
                end
            end
            ST_TRACK, ST_BAND, ST_FAILSAFE: begin
                if (sleep_i) begin
                    state_d = ST_STANDBY;
                end else begin
                    unique case (lvl_i)
                        LVL_HIGH: begin
                            state_d = ST_TRACK;
                            cnt_d   = '0;
                            rx_d    = 1'b1;
                        end
                        LVL_LOW: begin
                            state_d = ST_TRACK;
                            cnt_d   = '0;
                            rx_d    = 1'b0;
                        end
                        default: begin
                            if (state_q == ST_FAILSAFE) begin
                                state_d = ST_FAILSAFE;
                            end else if (cnt_q == LAST) begin
                                state_d = ST_FAILSAFE;
                                cnt_d   = '0;
                                rx_d    = 1'b1;
                            end else begin
                                state_d = ST_BAND;
                                cnt_d   = cnt_q + 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: state_d = ST_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_TRACK;
            cnt_q   <= '0;
            rx_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
        end
    end

    // Outputs
    always_comb begin
        rx_o    = rx_q;
        fault_o = (state_q == ST_FAILSAFE);
    end

    // R4
    fault_forces_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> rx_o);

    // R4
    timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    // R1
    high_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && state_q != ST_STANDBY && lvl_i == LVL_HIGH) |=> (rx_o && !fault_o));

    // R2
    low_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sleep_i && state_q != ST_STANDBY && lvl_i == LVL_LOW) |=> (!rx_o && !fault_o));

    // R10
    standby_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STANDBY && sleep_i) |=> ($stable(rx_o) && $stable(cnt_q) && !fault_o));

    // R11
    wake_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STANDBY && !sleep_i) |=> (rx_o && !fault_o && cnt_q == '0));

endmodule

// File: rtl/bus_rx_guard.sv
module bus_rx_guard
    import bus_rx_guard_pkg::*;
#(
    parameter int CLK_KHZ     = 250000,
    parameter int FS_CYCLES   = CLK_KHZ / 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic below_i,
    input  logic de_pin,
    input  logic de_open,
    input  logic d_pin,
    input  logic d_open,
    input  logic re_pin,
    input  logic re_open,
    output logic rx_data,
    output logic rx_oe,
    output logic drv_a,
    output logic drv_b,
    output logic drv_oe,
    output logic standby,
    output logic fault
);

    logic [1:0]          flags_sync;
    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] opens;
    bus_lvl_e            lvl;

    assign pins  = {re_pin, d_pin, de_pin};
    assign opens = {re_open, d_open, de_open};

    flag_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .async_i({above_i, below_i}),
        .sync_o (flags_sync)
    );

    assign lvl = classify(flags_sync[1], flags_sync[0]);

    pin_decoder u_pins (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pin_i    (pins),
        .open_i   (opens),
        .drv_oe_o (drv_oe),
        .drv_a_o  (drv_a),
        .drv_b_o  (drv_b),
        .rx_oe_o  (rx_oe),
        .standby_o(standby)
    );

    rx_failsafe_fsm #(
        .FS_CYCLES(FS_CYCLES)
    ) u_fsm (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .lvl_i  (lvl),
        .sleep_i(standby),
        .rx_o   (rx_data),
        .fault_o(fault)
    );

endmodule

// File: tb/bus_rx_guard_bench.sv
`timescale 1ns/1ps
module bus_rx_guard_bench;

    localparam int FS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_i = 1'b0, below_i = 1'b0;
    logic de_pin = 1'b0, de_open = 1'b0;
    logic d_pin = 1'b1, d_open = 1'b0;
    logic re_pin = 1'b0, re_open = 1'b0;
    logic rx_data, rx_oe, drv_a, drv_b, drv_oe, standby, fault;

    always #2 clk = ~clk;

    bus_rx_guard #(.FS_CYCLES(FS)) u_bus_rx_guard (
        .clk(clk), .rst_n(rst_n), .above_i(above_i), .below_i(below_i),
        .de_pin(de_pin), .de_open(de_open), .d_pin(d_pin), .d_open(d_open),
        .re_pin(re_pin), .re_open(re_open), .rx_data(rx_data), .rx_oe(rx_oe),
        .drv_a(drv_a), .drv_b(drv_b), .drv_oe(drv_oe), .standby(standby), .fault(fault)
    );

    typedef struct {
        int    due;
        int    sig;
        logic  val;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic sig_val(int s);
        case (s)
            0: return rx_data;
            1: return rx_oe;
            2: return drv_a;
            3: return drv_b;
            4: return drv_oe;
            5: return standby;
            default: return fault;
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            0: return "rx_data";
            1: return "rx_oe";
            2: return "drv_a";
            3: return "drv_b";
            4: return "drv_oe";
            5: return "standby";
            default: return "fault";
        endcase
    endfunction

    // Monitor: compare items due in this cycle
    always begin
        @(posedge clk);
        #1;
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                checks++;
                if (sig_val(sb_q[i].sig) !== sb_q[i].val) begin
                    errors++;
                    $display("FAIL %s: %s at cycle %0d actual %b expected %b",
                             sb_q[i].tag, sig_name(sb_q[i].sig), cyc,
                             sig_val(sb_q[i].sig), sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic expect_at(int due, int sig, logic v, string tag);
        exp_item_t it;
        it.due = due; it.sig = sig; it.val = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_flags(logic a, logic b);
        above_i = a;
        below_i = b;
    endtask

    localparam int S_RX = 0, S_RXOE = 1, S_A = 2, S_B = 3, S_DOE = 4, S_SB = 5, S_FLT = 6;

    int base;

    initial begin
        // R12: values while reset is held
        @(negedge clk);
        expect_at(cyc + 1, S_RX, 1'b1, "R12");
        expect_at(cyc + 1, S_FLT, 1'b0, "R12");
        idle(3);
        // Release reset and present a low line together
        rst_n = 1'b1;
        set_flags(1'b0, 1'b1);
        base = cyc;
        expect_at(base + 1, S_RX, 1'b1, "R12");
        expect_at(base + 1, S_FLT, 1'b0, "R12");
        expect_at(base + 2, S_RX, 1'b1, "R2");
        expect_at(base + 3, S_RX, 1'b0, "R2");
        expect_at(base + 3, S_FLT, 1'b0, "R2");
        idle(6);

        // R1: high line, three-edge latency
        set_flags(1'b1, 1'b0);
        base = cyc;
        expect_at(base + 2, S_RX, 1'b0, "R1");
        expect_at(base + 3, S_RX, 1'b1, "R1");
        idle(6);

        // R3 / R4: low then in-band run until failsafe
        set_flags(1'b0, 1'b1);
        idle(5);
        set_flags(1'b0, 1'b0);
        base = cyc;
        expect_at(base + 3, S_RX, 1'b0, "R3");
        expect_at(base + FS + 1, S_RX, 1'b0, "R3");
        expect_at(base + FS + 1, S_FLT, 1'b0, "R3");
        expect_at(base + FS + 2, S_RX, 1'b1, "R4");
        expect_at(base + FS + 2, S_FLT, 1'b1, "R4");
        expect_at(base + FS + 6, S_FLT, 1'b1, "R4");
        idle(FS + 8);

        // R5: valid low leaves failsafe
        set_flags(1'b0, 1'b1);
        base = cyc;
        expect_at(base + 2, S_FLT, 1'b1, "R5");
        expect_at(base + 3, S_FLT, 1'b0, "R5");
        expect_at(base + 3, S_RX, 1'b0, "R5");
        idle(5);

        // R5: partial in-band run, a valid high, then a full run
        set_flags(1'b0, 1'b0);
        base = cyc;
        idle(5);
        set_flags(1'b1, 1'b0);
        @(negedge clk);
        set_flags(1'b0, 1'b0);
        expect_at(base + 7, S_RX, 1'b0, "R5");
        expect_at(base + 8, S_RX, 1'b1, "R5");
        expect_at(base + FS + 7, S_FLT, 1'b0, "R5");
        expect_at(base + FS + 8, S_FLT, 1'b1, "R5");
        idle(FS + 12);

        // R6: both flags set count as in-band
        set_flags(1'b0, 1'b1);
        idle(5);
        set_flags(1'b1, 1'b1);
        base = cyc;
        expect_at(base + FS + 1, S_RX, 1'b0, "R6");
        expect_at(base + FS + 1, S_FLT, 1'b0, "R6");
        expect_at(base + FS + 2, S_FLT, 1'b1, "R6");
        idle(FS + 6);

        // R8: driver decode
        set_flags(1'b1, 1'b0);
        de_pin = 1'b1; d_pin = 1'b0;
        expect_at(cyc + 1, S_DOE, 1'b1, "R8");
        expect_at(cyc + 1, S_A, 1'b0, "R8");
        expect_at(cyc + 1, S_B, 1'b1, "R8");
        expect_at(cyc + 1, S_SB, 1'b0, "R10");
        idle(2);
        d_pin = 1'b1;
        expect_at(cyc + 1, S_A, 1'b1, "R8");
        expect_at(cyc + 1, S_B, 1'b0, "R8");
        idle(2);
        // R7: receiver enable
        re_pin = 1'b1;
        expect_at(cyc + 1, S_RXOE, 1'b0, "R7");
        expect_at(cyc + 1, S_SB, 1'b0, "R10");
        idle(2);
        re_pin = 1'b0;
        expect_at(cyc + 1, S_RXOE, 1'b1, "R7");
        idle(2);
        de_pin = 1'b0; re_pin = 1'b1;
        expect_at(cyc + 1, S_DOE, 1'b0, "R8");
        expect_at(cyc + 1, S_SB, 1'b1, "R10");
        idle(2);

        // R9: unconnected pins
        re_pin = 1'b0; de_pin = 1'b1; de_open = 1'b1;
        expect_at(cyc + 1, S_DOE, 1'b0, "R9");
        idle(2);
        de_open = 1'b0; d_pin = 1'b0; d_open = 1'b1;
        expect_at(cyc + 1, S_A, 1'b1, "R9");
        expect_at(cyc + 1, S_B, 1'b0, "R9");
        idle(2);
        d_open = 1'b0; re_pin = 1'b1; re_open = 1'b1;
        expect_at(cyc + 1, S_RXOE, 1'b1, "R9");
        idle(2);
        de_pin = 1'b0;
        expect_at(cyc + 1, S_SB, 1'b0, "R9");
        idle(2);
        re_open = 1'b0; re_pin = 1'b0; d_pin = 1'b1;
        idle(2);

        // R10 / R11: standby freezes, wake restarts
        set_flags(1'b0, 1'b1);
        idle(6);
        de_pin = 1'b0; re_pin = 1'b1;
        set_flags(1'b0, 1'b0);
        base = cyc;
        expect_at(base + 1, S_SB, 1'b1, "R10");
        expect_at(base + 1, S_RX, 1'b0, "R10");
        expect_at(base + 12, S_RX, 1'b0, "R10");
        expect_at(base + 15, S_FLT, 1'b0, "R10");
        idle(10);
        set_flags(1'b1, 1'b0);
        expect_at(base + 20, S_RX, 1'b0, "R10");
        expect_at(base + 21, S_RX, 1'b0, "R10");
        idle(11);
        re_pin = 1'b0;
        set_flags(1'b0, 1'b0);
        expect_at(base + 22, S_SB, 1'b0, "R11");
        expect_at(base + 22, S_RX, 1'b1, "R11");
        expect_at(base + 22, S_FLT, 1'b0, "R11");
        expect_at(base + 23 + FS - 1, S_FLT, 1'b0, "R11");
        expect_at(base + 23 + FS, S_FLT, 1'b1, "R11");
        idle(FS + 10);

        idle(4);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items never compared, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule